// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block is the control sequencer that a small 32-bit microcontroller core uses for its three fixed memory sequences. After reset it fetches the initial main stack pointer and the reset vector. When the core accepts an exception, the sequencer saves an eight-word context frame on the stack and writes the return code into the link register. It then switches to handler mode and loads the handler address from the vector table. When the core loads one of the two return codes into the PC, the sequencer sets the mode from that code, restores the frame and releases the stack space.

The core gives it two request channels, one for entry and one for return. Each is a valid/ready pair. A request transfers on a clock edge where both valid and ready are high. Ready is low for the whole of a running sequence, so the core must hold or drop its request. Nothing is queued. Memory is a single-word port with request/ready back-pressure: the sequencer holds the request, address, write enable and write data until ready is seen high, and one word moves on each edge where request and ready are both high. The core reads its context registers through a small read port. It receives results through a write-back port with one register per cycle. Busy, mode and the interrupt-status field are plain status outputs.

Top module: `exc_seq`

## Requirements
- R1: After reset is released the block reads address 0x00 and writes that word to SP (write-back select 8). It then reads address 0x04 and writes that word with bit 0 cleared to PC (select 6). During reset and this sequence busy is high. Afterwards the mode is thread (mode_handler=0) and ipsr is 0.
- R2: ent_ready is high only when the block is idle. ret_ready is high only when the block is idle and ent_valid is low, so an entry request wins over a return request. A request raised while busy transfers nothing and causes no memory access and no write-back.
- R3: On an accepted entry, SP is written with sp_in minus 32 before any stack write.
- R4: The frame is pushed as eight writes to new_SP+4k, for k=0..7, in increasing k. Index k selects R0, R1, R2, R3, R12, LR, PC, PSR in that order. The data is ctx_rd_data with ctx_rd_idx=k, and write-back select k names the same register.
- R5: After the last push, LR (select 5) is written with 0xFFFFFFF9 if the entry came from thread mode and with 0xFFFFFFF1 if it came from handler mode. In the same step the mode becomes handler and ipsr takes the exception number.
- R6: The block then reads address num*4 and writes that word with bit 0 cleared to PC.
- R7: An accepted return with code 0xFFFFFFF9 sets thread mode and code 0xFFFFFFF1 sets handler mode, in the cycle after acceptance and before any pop. Any other code is accepted as an ordinary branch: there is no sequence, and mode and ipsr are unchanged.
- R8: A return reads sp_in+4k for k=0..7 and writes each word back under select k. ipsr takes bits 5:0 of the popped status word, and SP is finally written with sp_in plus 32.
- R9: While a memory request waits with ready low, the request, address and write enable are held unchanged.
- R10: Busy is high from the cycle after an accepted entry or exception return until its last write-back. While idle there is no memory request and no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ent_valid | input | 1 | Accepted-exception request valid |
| ent_ready | output | 1 | Entry request can transfer |
| ent_num | input | NUM_W | Exception number of the request |
| ret_valid | input | 1 | PC was loaded with a possible return code |
| ret_ready | output | 1 | Return request can transfer |
| ret_code | input | DATA_W | Value loaded into the PC |
| sp_in | input | DATA_W | Current stack pointer from the core |
| ctx_rd_idx | output | 3 | Frame register index to read |
| ctx_rd_data | input | DATA_W | Value of the selected context register |
| mem_req | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts/completes the access this cycle |
| mem_addr | output | DATA_W | Byte address of the word |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with mem_ready |
| wb_valid | output | 1 | Register write-back strobe |
| wb_sel | output | 4 | Register: 0-3 R0-R3, 4 R12, 5 LR, 6 PC, 7 PSR, 8 SP |
| wb_data | output | DATA_W | Write-back value |
| busy | output | 1 | A sequence is running |
| mode_handler | output | 1 | 1 = handler mode, 0 = thread mode |
| ipsr | output | NUM_W | Interrupt-status exception number |

## Verification
The bench builds the block at its defaults of 32-bit data and a 6-bit exception number. With these values every vector address, up to 0xFC, and a full stack frame both fit inside a 1 KiB word memory model, so vector reads, frame writes and frame reads can all be compared word for word against one bench memory. The bench runs one nested pair of entries, from thread and then from handler, and returns with both codes. It passes an ordinary-branch value and requests that collide with a running sequence or with each other. Part of the run uses a pseudo-random ready pattern and part uses a memory that is always ready, so both stalled and back-to-back transfers occur in each kind of sequence.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  localparam int FRAME_WORDS = 8;
  localparam int FRAME_IDX_W = 3;

  typedef enum logic [3:0] {
    WB_R0  = 4'd0,
    WB_R1  = 4'd1,
    WB_R2  = 4'd2,
    WB_R3  = 4'd3,
    WB_R12 = 4'd4,
    WB_LR  = 4'd5,
    WB_PC  = 4'd6,
    WB_PSR = 4'd7,
    WB_SP  = 4'd8
  } wb_sel_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RST_SP,
    S_RST_PC,
    S_ENT_SP,
    S_PUSH,
    S_ENT_LR,
    S_VEC,
    S_POP,
    S_RET_SP
  } seq_state_e;

endpackage

// File: rtl/exc_seq_retdec.sv
module exc_seq_retdec #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] code,
  output logic              is_exc,
  output logic              to_handler
);
  localparam logic [DATA_W-1:0] CODE_THREAD  = {{(DATA_W-4){1'b1}}, 4'h9};
  localparam logic [DATA_W-1:0] CODE_HANDLER = {{(DATA_W-4){1'b1}}, 4'h1};

  logic hit_thread;
  logic hit_handler;

  always_comb begin
    hit_thread  = (code == CODE_THREAD);
    hit_handler = (code == CODE_HANDLER);
    is_exc      = hit_thread | hit_handler;
    to_handler  = hit_handler;
  end
endmodule

// File: rtl/exc_seq_agu.sv
module exc_seq_agu
  import exc_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_W  = 6
) (
  input  seq_state_e             state,
  input  logic [DATA_W-1:0]      base,
  input  logic [FRAME_IDX_W-1:0] idx,
  input  logic [NUM_W-1:0]       num,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [DATA_W-1:0]      mem_addr
);
  localparam logic [DATA_W-1:0] SP_SLOT = '0;
  localparam logic [DATA_W-1:0] PC_SLOT = DATA_W'(4);

  logic [DATA_W-1:0] frame_off;
  logic [DATA_W-1:0] vec_off;

  always_comb begin
    frame_off = {{(DATA_W-FRAME_IDX_W-2){1'b0}}, idx, 2'b00};
    vec_off   = {{(DATA_W-NUM_W-2){1'b0}}, num, 2'b00};
  end

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = '0;
    case (state)
      S_RST_SP: begin
        mem_req  = 1'b1;
        mem_addr = SP_SLOT;
      end
      S_RST_PC: begin
        mem_req  = 1'b1;
        mem_addr = PC_SLOT;
      end
      S_PUSH: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = base + frame_off;
      end
      S_POP: begin
        mem_req  = 1'b1;
        mem_addr = base + frame_off;
      end
      S_VEC: begin
        mem_req  = 1'b1;
        mem_addr = vec_off;
      end
      default: begin
        mem_req  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_W  = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ent_valid,
  input  logic [NUM_W-1:0]       ent_num,
  output logic                   ent_ready,
  input  logic                   ret_valid,
  output logic                   ret_ready,
  input  logic                   ret_is_exc,
  input  logic                   ret_to_handler,
  input  logic [DATA_W-1:0]      sp_in,
  input  logic                   mem_ready,
  input  logic [DATA_W-1:0]      mem_rdata,
  output seq_state_e             state,
  output logic [FRAME_IDX_W-1:0] idx,
  output logic [DATA_W-1:0]      base,
  output logic [NUM_W-1:0]       num,
  output logic                   wb_valid,
  output wb_sel_e                wb_sel,
  output logic [DATA_W-1:0]      wb_data,
  output logic                   busy,
  output logic                   mode_handler,
  output logic [NUM_W-1:0]       ipsr
);
  localparam logic [DATA_W-1:0]      FRAME_BYTES  = DATA_W'(FRAME_WORDS * 4);
  localparam logic [FRAME_IDX_W-1:0] LAST_IDX     = FRAME_IDX_W'(FRAME_WORDS - 1);
  localparam logic [DATA_W-1:0]      CODE_THREAD  = {{(DATA_W-4){1'b1}}, 4'h9};
  localparam logic [DATA_W-1:0]      CODE_HANDLER = {{(DATA_W-4){1'b1}}, 4'h1};

  logic from_handler;
  logic ent_fire;
  logic ret_fire;
  logic idle;

  always_comb begin
    idle      = (state == S_IDLE);
    ent_ready = idle;
    ret_ready = idle & ~ent_valid;
    ent_fire  = ent_valid & ent_ready;
    ret_fire  = ret_valid & ret_ready;
    busy      = ~idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_RST_SP;
      idx          <= '0;
      base         <= '0;
      num          <= '0;
      from_handler <= 1'b0;
      mode_handler <= 1'b0;
      ipsr         <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (ent_fire) begin
            base         <= sp_in - FRAME_BYTES;
            num          <= ent_num;
            from_handler <= mode_handler;
            idx          <= '0;
            state        <= S_ENT_SP;
          end else if (ret_fire && ret_is_exc) begin
            base         <= sp_in;
            mode_handler <= ret_to_handler;
            idx          <= '0;
            state        <= S_POP;
          end
        end
        S_RST_SP: if (mem_ready) state <= S_RST_PC;
        S_RST_PC: if (mem_ready) state <= S_IDLE;
        S_ENT_SP: state <= S_PUSH;
        S_PUSH: begin
          if (mem_ready) begin
            if (idx == LAST_IDX) state <= S_ENT_LR;
            else                 idx   <= idx + 1'b1;
          end
        end
        S_ENT_LR: begin
          mode_handler <= 1'b1;
          ipsr         <= num;
          state        <= S_VEC;
        end
        S_VEC: if (mem_ready) state <= S_IDLE;
        S_POP: begin
          if (mem_ready) begin
            if (idx == LAST_IDX) begin
              ipsr  <= mem_rdata[NUM_W-1:0];
              state <= S_RET_SP;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        S_RET_SP: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    wb_valid = 1'b0;
    wb_sel   = WB_SP;
    wb_data  = base;
    case (state)
      S_RST_SP: begin
        wb_valid = mem_ready;
        wb_sel   = WB_SP;
        wb_data  = mem_rdata;
      end
      S_RST_PC, S_VEC: begin
        wb_valid = mem_ready;
        wb_sel   = WB_PC;
        wb_data  = {mem_rdata[DATA_W-1:1], 1'b0};
      end
      S_ENT_SP: begin
        wb_valid = 1'b1;
        wb_sel   = WB_SP;
        wb_data  = base;
      end
      S_ENT_LR: begin
        wb_valid = 1'b1;
        wb_sel   = WB_LR;
        wb_data  = from_handler ? CODE_HANDLER : CODE_THREAD;
      end
      S_POP: begin
        wb_valid = mem_ready;
        wb_sel   = wb_sel_e'({1'b0, idx});
        wb_data  = mem_rdata;
      end
      S_RET_SP: begin
        wb_valid = 1'b1;
        wb_sel   = WB_SP;
        wb_data  = base + FRAME_BYTES;
      end
      default: wb_valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_W  = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ent_valid,
  output logic                   ent_ready,
  input  logic [NUM_W-1:0]       ent_num,
  input  logic                   ret_valid,
  output logic                   ret_ready,
  input  logic [DATA_W-1:0]      ret_code,
  input  logic [DATA_W-1:0]      sp_in,
  output logic [FRAME_IDX_W-1:0] ctx_rd_idx,
  input  logic [DATA_W-1:0]      ctx_rd_data,
  output logic                   mem_req,
  input  logic                   mem_ready,
  output logic [DATA_W-1:0]      mem_addr,
  output logic                   mem_we,
  output logic [DATA_W-1:0]      mem_wdata,
  input  logic [DATA_W-1:0]      mem_rdata,
  output logic                   wb_valid,
  output logic [3:0]             wb_sel,
  output logic [DATA_W-1:0]      wb_data,
  output logic                   busy,
  output logic                   mode_handler,
  output logic [NUM_W-1:0]       ipsr
);
  seq_state_e             state;
  logic [FRAME_IDX_W-1:0] idx;
  logic [DATA_W-1:0]      base;
  logic [NUM_W-1:0]       num;
  logic                   ret_is_exc;
  logic                   ret_to_handler;
  wb_sel_e                wb_sel_enum;

  exc_seq_retdec #(.DATA_W(DATA_W)) u_retdec (
    .code       (ret_code),
    .is_exc     (ret_is_exc),
    .to_handler (ret_to_handler)
  );

  exc_seq_ctrl #(.DATA_W(DATA_W), .NUM_W(NUM_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .ent_valid      (ent_valid),
    .ent_num        (ent_num),
    .ent_ready      (ent_ready),
    .ret_valid      (ret_valid),
    .ret_ready      (ret_ready),
    .ret_is_exc     (ret_is_exc),
    .ret_to_handler (ret_to_handler),
    .sp_in          (sp_in),
    .mem_ready      (mem_ready),
    .mem_rdata      (mem_rdata),
    .state          (state),
    .idx            (idx),
    .base           (base),
    .num            (num),
    .wb_valid       (wb_valid),
    .wb_sel         (wb_sel_enum),
    .wb_data        (wb_data),
    .busy           (busy),
    .mode_handler   (mode_handler),
    .ipsr           (ipsr)
  );

  exc_seq_agu #(.DATA_W(DATA_W), .NUM_W(NUM_W)) u_agu (
    .state    (state),
    .base     (base),
    .idx      (idx),
    .num      (num),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
  );

  assign wb_sel     = wb_sel_enum;
  assign ctx_rd_idx = idx;
  assign mem_wdata  = ctx_rd_data;
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
  parameter int DATA_W = 32,
  parameter int NUM_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ent_valid,
  input logic              ent_ready,
  input logic              ret_valid,
  input logic              ret_ready,
  input logic [DATA_W-1:0] ret_code,
  input logic              mem_req,
  input logic              mem_ready,
  input logic [DATA_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              wb_valid,
  input logic              busy,
  input logic              mode_handler
);
  localparam logic [DATA_W-1:0] CODE_THREAD  = {{(DATA_W-4){1'b1}}, 4'h9};
  localparam logic [DATA_W-1:0] CODE_HANDLER = {{(DATA_W-4){1'b1}}, 4'h1};

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r2_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!ent_ready && !ret_ready));

  a_r2_entry_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> !ret_ready);

  a_r10_entry_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && ent_ready) |=> busy);

  a_r7_ret_thread: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_ready && ret_code == CODE_THREAD) |=> (busy && !mode_handler));

  a_r7_ret_handler: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_ready && ret_code == CODE_HANDLER) |=> (busy && mode_handler));

  a_r7_plain_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_ready && ret_code != CODE_THREAD && ret_code != CODE_HANDLER)
      |=> (!busy && $stable(mode_handler)));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !wb_valid));
endmodule

bind exc_seq exc_seq_chk #(.DATA_W(DATA_W), .NUM_W(NUM_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ent_valid    (ent_valid),
  .ent_ready    (ent_ready),
  .ret_valid    (ret_valid),
  .ret_ready    (ret_ready),
  .ret_code     (ret_code),
  .mem_req      (mem_req),
  .mem_ready    (mem_ready),
  .mem_addr     (mem_addr),
  .mem_we       (mem_we),
  .wb_valid     (wb_valid),
  .busy         (busy),
  .mode_handler (mode_handler)
);

// File: tb/tb_exc_seq.sv
module tb_exc_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int NW = 6;
  localparam logic [31:0] CODE_T = 32'hFFFF_FFF9;
  localparam logic [31:0] CODE_H = 32'hFFFF_FFF1;
  localparam int EV_RD = 0;
  localparam int EV_WR = 1;
  localparam int EV_WB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ent_valid = 1'b0;
  logic ent_ready;
  logic [NW-1:0] ent_num = '0;
  logic ret_valid = 1'b0;
  logic ret_ready;
  logic [DW-1:0] ret_code = '0;
  logic [DW-1:0] sp_in;
  logic [2:0] ctx_rd_idx;
  logic [DW-1:0] ctx_rd_data;
  logic mem_req;
  logic mem_ready = 1'b0;
  logic [DW-1:0] mem_addr;
  logic mem_we;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic wb_valid;
  logic [3:0] wb_sel;
  logic [DW-1:0] wb_data;
  logic busy;
  logic mode_handler;
  logic [NW-1:0] ipsr;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_seq #(.DATA_W(DW), .NUM_W(NW)) dut (
    .clk(clk), .rst_n(rst_n),
    .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_num(ent_num),
    .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_code(ret_code),
    .sp_in(sp_in), .ctx_rd_idx(ctx_rd_idx), .ctx_rd_data(ctx_rd_data),
    .mem_req(mem_req), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .wb_valid(wb_valid), .wb_sel(wb_sel), .wb_data(wb_data),
    .busy(busy), .mode_handler(mode_handler), .ipsr(ipsr)
  );

  logic [31:0] mem [0:255];
  logic [31:0] ctx [0:7];
  logic [31:0] sp_model = '0;
  logic stall_on = 1'b1;
  logic [7:0] lfsr = 8'hA5;

  assign ctx_rd_data = ctx[ctx_rd_idx];
  assign sp_in = sp_model;

  typedef struct {
    int          kind;
    logic [31:0] key;
    logic [31:0] data;
    string       req;
  } ev_t;
  ev_t expq[$];

  int mon_chk = 0, mon_fail = 0, nchk = 0, nfail = 0;

  task automatic expect_ev(input int kind, input logic [31:0] key,
                           input logic [31:0] data, input string req);
    ev_t e;
    e.kind = kind; e.key = key; e.data = data; e.req = req;
    expq.push_back(e);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  // Scoreboard monitor: decides ready at each falling edge, then records the
  // transfer and write-back that the next rising edge will perform.
  initial begin
    forever begin
      @(negedge clk);
      mem_ready = stall_on ? (lfsr[0] | lfsr[2]) : 1'b1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_rdata = mem[mem_addr[9:2]];
      #1;
      if (rst_n) begin
        if (mem_req && mem_ready) begin
          if (mem_we) begin
            mem[mem_addr[9:2]] = mem_wdata;
            take(EV_WR, mem_addr, mem_wdata);
          end else begin
            take(EV_RD, mem_addr, 32'h0);
          end
        end
        if (wb_valid) begin
          take(EV_WB, {28'd0, wb_sel}, wb_data);
          if (wb_sel == 4'd8) sp_model = wb_data;
        end
      end
    end
  end

  task automatic take(input int kind, input logic [31:0] key, input logic [31:0] data);
    ev_t e;
    mon_chk++;
    if (expq.size() == 0) begin
      mon_fail++;
      $display("FAIL R2 unexpected event kind=%0d actual=%h expected=none", kind, key);
    end else begin
      e = expq.pop_front();
      if (e.kind != kind || e.key != key || (kind != EV_RD && e.data != data)) begin
        mon_fail++;
        $display("FAIL %s event kind=%0d/%0d actual=%h:%h expected=%h:%h",
                 e.req, kind, e.kind, key, data, e.key, e.data);
      end
    end
  endtask

  task automatic wait_idle();
    step();
    while (busy) step();
  endtask

  task automatic do_entry(input logic [NW-1:0] num, input logic [31:0] lr_code,
                          input bit with_ret);
    logic [31:0] nb;
    nb = sp_model - 32'd32;
    expect_ev(EV_WB, 32'd8, nb, "R3");
    for (int k = 0; k < 8; k++) expect_ev(EV_WR, nb + 32'(4*k), ctx[k], "R4");
    expect_ev(EV_WB, 32'd5, lr_code, "R5");
    expect_ev(EV_RD, {24'd0, num, 2'b00}, 32'h0, "R6");
    expect_ev(EV_WB, 32'd6, {mem[num][31:1], 1'b0}, "R6");
    step();
    ent_valid = 1'b1; ent_num = num;
    if (with_ret) begin ret_valid = 1'b1; ret_code = CODE_H; end
    #1;
    chk(ent_ready == 1'b1, "R2", "ent_ready idle", 32'(ent_ready), 32'd1);
    if (with_ret) chk(ret_ready == 1'b0, "R2", "ret_ready with entry", 32'(ret_ready), 32'd0);
    step();
    ent_valid = 1'b0; ret_valid = 1'b0;
    chk(busy == 1'b1, "R10", "busy after entry", 32'(busy), 32'd1);
    // R2: requests raised during the sequence must not transfer
    ent_valid = 1'b1; ent_num = 6'd5; ret_valid = 1'b1; ret_code = CODE_T;
    #1;
    chk(!ent_ready && !ret_ready, "R2", "ready while busy", {ent_ready, ret_ready}, 32'd0);
    step(); step();
    ent_valid = 1'b0; ret_valid = 1'b0;
    wait_idle();
    chk(expq.size() == 0, "R4", "entry events left", expq.size(), 32'd0);
    chk(mode_handler == 1'b1, "R5", "mode after entry", 32'(mode_handler), 32'd1);
    chk(ipsr == num, "R5", "ipsr after entry", 32'(ipsr), 32'(num));
  endtask

  task automatic do_ret(input logic [31:0] code, input bit exp_mode);
    logic [31:0] b;
    logic [31:0] psr;
    b = sp_model;
    for (int k = 0; k < 8; k++) begin
      expect_ev(EV_RD, b + 32'(4*k), 32'h0, "R8");
      expect_ev(EV_WB, 32'(k), mem[b[9:2] + 8'(k)], "R8");
    end
    expect_ev(EV_WB, 32'd8, b + 32'd32, "R8");
    psr = mem[b[9:2] + 8'd7];
    step();
    ret_valid = 1'b1; ret_code = code;
    #1;
    chk(ret_ready == 1'b1, "R2", "ret_ready idle", 32'(ret_ready), 32'd1);
    step();
    ret_valid = 1'b0;
    chk(busy == 1'b1, "R10", "busy after return", 32'(busy), 32'd1);
    chk(mode_handler == exp_mode, "R7", "mode before pops", 32'(mode_handler), 32'(exp_mode));
    wait_idle();
    chk(expq.size() == 0, "R8", "return events left", expq.size(), 32'd0);
    chk(ipsr == psr[NW-1:0], "R8", "ipsr restored", 32'(ipsr), 32'(psr[NW-1:0]));
    chk(mode_handler == exp_mode, "R7", "mode after return", 32'(mode_handler), 32'(exp_mode));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nchk + mon_chk - nfail - mon_fail, nchk + mon_chk + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[0]  = 32'h0000_0200;
    mem[1]  = 32'h0000_1235;
    mem[3]  = 32'h0000_4000;
    mem[16] = 32'h0000_3001;
    for (int k = 0; k < 7; k++) ctx[k] = 32'hA000_0000 + 32'(k * 32'h111);
    ctx[7] = 32'h0100_0000;

    // R1: reset sequence expectations
    expect_ev(EV_RD, 32'h0, 32'h0, "R1");
    expect_ev(EV_WB, 32'd8, 32'h0000_0200, "R1");
    expect_ev(EV_RD, 32'h4, 32'h0, "R1");
    expect_ev(EV_WB, 32'd6, 32'h0000_1234, "R1");

    step(); step();
    chk(busy == 1'b1, "R1", "busy in reset", 32'(busy), 32'd1);
    chk(mode_handler == 1'b0, "R1", "mode in reset", 32'(mode_handler), 32'd0);
    chk(ipsr == '0, "R1", "ipsr in reset", 32'(ipsr), 32'd0);
    chk(ent_ready == 1'b0, "R2", "ent_ready in reset", 32'(ent_ready), 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    wait_idle();
    chk(expq.size() == 0, "R1", "reset events left", expq.size(), 32'd0);
    chk(sp_model == 32'h200, "R1", "SP after reset", sp_model, 32'h200);
    chk(mode_handler == 1'b0, "R1", "thread after reset", 32'(mode_handler), 32'd0);

    // Entry from thread mode with stalls (R3 R4 R5 R6 R9)
    do_entry(6'd16, CODE_T, 1'b0);

    // Nested entry from handler mode, memory always ready, colliding return
    for (int k = 0; k < 7; k++) ctx[k] = 32'hB000_0000 + 32'(k);
    ctx[7] = 32'h0100_0010;
    stall_on = 1'b0;
    do_entry(6'd3, CODE_H, 1'b1);

    // R7: ordinary branch value
    step();
    ret_valid = 1'b1; ret_code = 32'h0800_0000;
    #1;
    chk(ret_ready == 1'b1, "R7", "plain branch ready", 32'(ret_ready), 32'd1);
    step();
    ret_valid = 1'b0;
    step(); step();
    chk(busy == 1'b0, "R7", "no sequence on branch", 32'(busy), 32'd0);
    chk(mode_handler == 1'b1, "R7", "mode kept on branch", 32'(mode_handler), 32'd1);
    chk(ipsr == 6'd3, "R7", "ipsr kept on branch", 32'(ipsr), 32'd3);
    chk(expq.size() == 0, "R7", "no events on branch", expq.size(), 32'd0);

    // R7 R8: return to handler, then to thread with stalls
    do_ret(CODE_H, 1'b1);
    chk(sp_model == 32'h1E0, "R8", "SP after first return", sp_model, 32'h1E0);
    stall_on = 1'b1;
    do_ret(CODE_T, 1'b0);
    chk(sp_model == 32'h200, "R8", "SP after second return", sp_model, 32'h200);

    step();
    $display("%0d/%0d checks passed", nchk + mon_chk - nfail - mon_fail, nchk + mon_chk);
    $finish;
  end
endmodule